// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a bank of 32-bit control registers on a simple word-addressed bus with separate read and write strobes. Every write to an ordinary control register is gated by a lock. The bank comes out of reset locked. Software writes a 16-bit unlock key to one dedicated word to open the bank, and a different 16-bit lock key to another word to close it again. A read-only status word shows which state the bank is in.

Each word address has an access class: read-write, read-only, write-only, or undefined. An access that its class does not permit is dropped and answered with a one-cycle error flag. A write that the lock rejects is handled the same way. Bit 0 of the reset-control word raises a one-cycle system reset request when software writes it as 1 while the bank is unlocked.

The other control words are plain storage, with no meaning inside the block. Every response (read data and error flag) is registered. It appears in the cycle after the strobe.

Top module: `guarded_cfg_bank`

## Requirements
- R1: After reset, the status word (word 3) reads 1 (locked). The scratch word, the reset-control word and every storage word read 0. `bus_err` and `sys_reset_req` are low.
- R2: A write to word 1 whose low 16 bits equal 0x767B sets the lock state to 1. A write there with any other value leaves the lock state unchanged and raises no error.
- R3: A write to word 2 whose low 16 bits equal 0xDF0D clears the lock state to 0, whatever the current state and whatever the upper 16 bits are. Any other value is ignored and raises no error.
- R4: The status word (word 3) holds the lock state in bit 0 and reads 0 in all other bits. A write to it is dropped and raises `bus_err`.
- R5: While the bank is locked, a write to any read-write word is dropped and raises `bus_err`.
- R6: While the bank is unlocked, a write to a storage word (words CFG_BASE to CFG_BASE+NUM_CFG-1) is stored in full and reads back unchanged.
- R7: The scratch word (word 0) keeps only bit 0 of a written value. Its other bits read 0.
- R8: Writing the reset-control word (word 0x80) with bit 0 = 1 while unlocked drives `sys_reset_req` high for exactly the one cycle after the write. The stored word reads back as written. A locked or bit-0-clear write gives no pulse.
- R9: A read of a write-only word (words 1 and 2) or of an undefined word returns 0 with `bus_err` and changes no state.
- R10: A write to an undefined word, including the first word past the storage range, or to the identification word, is dropped and raises `bus_err`.
- R11: The identification word (word 0x14C) is read-only and returns the parameter ID_VALUE.
- R12: Read data and `bus_err` appear in the cycle after the strobe. `bus_rdata` is 0 and `bus_err` is low in cycles that follow no strobe. When both strobes are high, the write is performed and the read is ignored, so `bus_rdata` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | One-cycle error response |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the bank with NUM_CFG = 4 and CFG_BASE = 0x40, with the remaining parameters at their defaults. This places both the last storage word (0x43) and the first undefined word above it (0x44) within a few accesses, so the edge of the range decoder is exercised from both sides. ADDR_W = 10 keeps the reset-control and identification words reachable, together with the top undefined word 0x3FF.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_RO,
        ACC_WO,
        ACC_RW
    } acc_class_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_SCRATCH,
        K_LOCK,
        K_UNLOCK,
        K_STATUS,
        K_RSTCTL,
        K_ID,
        K_CFG
    } word_kind_e;

    localparam int unsigned W_SCRATCH = 'h000;
    localparam int unsigned W_LOCK    = 'h001;
    localparam int unsigned W_UNLOCK  = 'h002;
    localparam int unsigned W_STATUS  = 'h003;
    localparam int unsigned W_RSTCTL  = 'h080;
    localparam int unsigned W_ID      = 'h14C;

    localparam logic [15:0] LOCK_KEY   = 16'h767B;
    localparam logic [15:0] UNLOCK_KEY = 16'hDF0D;

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfg_bank_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int NUM_CFG  = 8,
    parameter int CFG_BASE = 'h040,
    localparam int IDX_W   = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output word_kind_e        kind,
    output acc_class_e        cls,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] off;

    always_comb begin
        off  = addr - ADDR_W'(CFG_BASE);
        idx  = off[IDX_W-1:0];
        kind = K_NONE;
        if (addr == ADDR_W'(W_SCRATCH))      kind = K_SCRATCH;
        else if (addr == ADDR_W'(W_LOCK))    kind = K_LOCK;
        else if (addr == ADDR_W'(W_UNLOCK))  kind = K_UNLOCK;
        else if (addr == ADDR_W'(W_STATUS))  kind = K_STATUS;
        else if (addr == ADDR_W'(W_RSTCTL))  kind = K_RSTCTL;
        else if (addr == ADDR_W'(W_ID))      kind = K_ID;
        else if (off < ADDR_W'(NUM_CFG))     kind = K_CFG;

        unique case (kind)
            K_SCRATCH, K_RSTCTL, K_CFG: cls = ACC_RW;
            K_LOCK, K_UNLOCK:           cls = ACC_WO;
            K_STATUS, K_ID:             cls = ACC_RO;
            default:                    cls = ACC_NONE;
        endcase
    end
endmodule

// File: rtl/cfg_key_gate.sv
module cfg_key_gate
    import cfg_bank_pkg::*;
(
    input  logic        wr_lock,
    input  logic        wr_unlock,
    input  logic [15:0] key,
    input  logic        locked_q,
    output logic        locked_d
);
    always_comb begin
        locked_d = locked_q;
        if (wr_lock && key == LOCK_KEY)
            locked_d = 1'b1;
        else if (wr_unlock && key == UNLOCK_KEY)
            locked_d = 1'b0;
    end
endmodule

// File: rtl/guarded_cfg_bank.sv
module guarded_cfg_bank
    import cfg_bank_pkg::*;
#(
    parameter int              ADDR_W   = 10,
    parameter int              DATA_W   = 32,
    parameter int              NUM_CFG  = 8,
    parameter int              CFG_BASE = 'h040,
    parameter logic [DATA_W-1:0] ID_VALUE = DATA_W'(32'h5EC0_0A11)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              sys_reset_req
);
    localparam int IDX_W = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;

    typedef struct packed {
        logic                           locked;
        logic                           scratch;
        logic [DATA_W-1:0]              rstctl;
        logic [NUM_CFG-1:0][DATA_W-1:0] cfg;
        logic [DATA_W-1:0]              rdata;
        logic                           err;
        logic                           rst_req;
    } state_t;

    state_t st_d, st_q;

    word_kind_e       kind;
    acc_class_e       cls;
    logic [IDX_W-1:0] idx;
    logic             locked_next;
    logic             lock_state;
    logic [DATA_W-1:0] rd_word;

    cfg_addr_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_CFG (NUM_CFG),
        .CFG_BASE(CFG_BASE)
    ) u_dec (
        .addr(bus_addr),
        .kind(kind),
        .cls (cls),
        .idx (idx)
    );

    cfg_key_gate u_gate (
        .wr_lock  (bus_wr && kind == K_LOCK),
        .wr_unlock(bus_wr && kind == K_UNLOCK),
        .key      (bus_wdata[15:0]),
        .locked_q (st_q.locked),
        .locked_d (locked_next)
    );

    always_comb begin
        rd_word = '0;
        unique case (kind)
            K_SCRATCH: rd_word = DATA_W'(st_q.scratch);
            K_STATUS:  rd_word = DATA_W'(st_q.locked);
            K_RSTCTL:  rd_word = st_q.rstctl;
            K_ID:      rd_word = ID_VALUE;
            K_CFG:     rd_word = st_q.cfg[idx];
            default:   rd_word = '0;
        endcase
    end

    always_comb begin
        st_d         = st_q;
        st_d.rdata   = '0;
        st_d.err     = 1'b0;
        st_d.rst_req = 1'b0;
        st_d.locked  = locked_next;
        if (bus_wr) begin
            unique case (cls)
                ACC_RO, ACC_NONE: st_d.err = 1'b1;
                ACC_WO:           st_d.err = 1'b0;
                ACC_RW: begin
                    if (st_q.locked) begin
                        st_d.err = 1'b1;
                    end else begin
                        unique case (kind)
                            K_SCRATCH: st_d.scratch = bus_wdata[0];
                            K_RSTCTL: begin
                                st_d.rstctl  = bus_wdata;
                                st_d.rst_req = bus_wdata[0];
                            end
                            K_CFG:     st_d.cfg[idx] = bus_wdata;
                            default:   st_d.err = 1'b1;
                        endcase
                    end
                end
                default:          st_d.err = 1'b1;
            endcase
        end else if (bus_rd) begin
            if (cls == ACC_RO || cls == ACC_RW)
                st_d.rdata = rd_word;
            else
                st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.locked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_state    = st_q.locked;
    assign bus_rdata     = st_q.rdata;
    assign bus_err       = st_q.err;
    assign sys_reset_req = st_q.rst_req;

endmodule

// File: rtl/guarded_cfg_bank_chk.sv
module guarded_cfg_bank_chk
    import cfg_bank_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       wkey,
    input logic              wbit0,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic              sys_reset_req,
    input logic              lock_state
);
    AST_LOCK_KEY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(W_LOCK) && wkey == LOCK_KEY |=> lock_state); // R2

    AST_UNLOCK_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(W_UNLOCK) && wkey == UNLOCK_KEY |=> !lock_state); // R3

    AST_STATUS_WR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(W_STATUS) |=> bus_err && $stable(lock_state)); // R4

    AST_LOCKED_WR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && lock_state && bus_addr == ADDR_W'(W_SCRATCH) |=> bus_err); // R5

    AST_RESET_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(bus_wr && !lock_state && bus_addr == ADDR_W'(W_RSTCTL) && wbit0)); // R8

    AST_WO_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && !bus_wr && (bus_addr == ADDR_W'(W_LOCK) || bus_addr == ADDR_W'(W_UNLOCK))
        |=> bus_err && bus_rdata == '0); // R9

    AST_ERR_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_wr || bus_rd)); // R12
endmodule

bind guarded_cfg_bank guarded_cfg_bank_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .wkey         (bus_wdata[15:0]),
    .wbit0        (bus_wdata[0]),
    .bus_rdata    (bus_rdata),
    .bus_err      (bus_err),
    .sys_reset_req(sys_reset_req),
    .lock_state   (lock_state)
);

// File: tb/guarded_cfg_bank_test.sv
module guarded_cfg_bank_test;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int NCFG   = 4;
    localparam int BASE   = 'h40;
    localparam logic [31:0] IDV = 32'h5EC0_0A11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_err;
    logic              sys_reset_req;

    int tests = 0;
    int fails = 0;
    logic [33:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    guarded_cfg_bank #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .NUM_CFG (NCFG),
        .CFG_BASE(BASE),
        .ID_VALUE(IDV)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_err      (bus_err),
        .sys_reset_req(sys_reset_req)
    );

    task automatic op(input logic wr, input logic rd, input int addr, input logic [31:0] data,
                      input logic [31:0] e_rd, input logic e_err, input logic e_rst, input string tag);
        @(negedge clk);
        bus_wr    = wr;
        bus_rd    = rd;
        bus_addr  = ADDR_W'(addr);
        bus_wdata = data;
        exp_q.push_back({e_rd, e_err, e_rst});
        tag_q.push_back(tag);
    endtask

    task automatic wr_op(input int addr, input logic [31:0] data, input logic e_err,
                         input logic e_rst, input string tag);
        op(1'b1, 1'b0, addr, data, 32'h0, e_err, e_rst, tag);
    endtask

    task automatic rd_op(input int addr, input logic [31:0] e_rd, input logic e_err, input string tag);
        op(1'b0, 1'b1, addr, 32'h0, e_rd, e_err, 1'b0, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    initial begin : monitor
        logic pend;
        logic [33:0] e;
        string t;
        forever begin
            @(posedge clk);
            pend = rst_n && (bus_wr || bus_rd);
            @(negedge clk);
            if (rst_n) begin
                if (pend) begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                end else begin
                    e = 34'h0;
                    t = "R12 idle";
                end
                tests++;
                if ({bus_rdata, bus_err, sys_reset_req} !== e) begin
                    fails++;
                    $display("FAIL %s: rdata=%h err=%b rst=%b expected rdata=%h err=%b rst=%b",
                             t, bus_rdata, bus_err, sys_reset_req, e[33:2], e[1], e[0]);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_op(3, 32'h1, 1'b0, "R1 status");
        rd_op(BASE, 32'h0, 1'b0, "R1 cfg0");
        rd_op('h80, 32'h0, 1'b0, "R1 rstctl");
        rd_op(0, 32'h0, 1'b0, "R1 scratch");
        // R5 locked writes dropped
        wr_op(BASE, 32'hAAAA_5555, 1'b1, 1'b0, "R5 locked wr");
        rd_op(BASE, 32'h0, 1'b0, "R5 readback");
        wr_op('h80, 32'h1, 1'b1, 1'b0, "R8 locked no pulse");
        // R3 wrong key ignored, right key with upper junk unlocks
        wr_op(2, 32'h0000_DF0E, 1'b0, 1'b0, "R3 bad key");
        rd_op(3, 32'h1, 1'b0, "R3 still locked");
        wr_op(2, 32'hFFFF_DF0D, 1'b0, 1'b0, "R3 unlock");
        rd_op(3, 32'h0, 1'b0, "R3 unlocked");
        // R6 storage
        wr_op(BASE, 32'hAAAA_5555, 1'b0, 1'b0, "R6 wr cfg0");
        wr_op(BASE + NCFG - 1, 32'h1234_5678, 1'b0, 1'b0, "R6 wr cfg top");
        rd_op(BASE, 32'hAAAA_5555, 1'b0, "R6 rd cfg0");
        rd_op(BASE + NCFG - 1, 32'h1234_5678, 1'b0, "R6 rd cfg top");
        // R7 scratch
        wr_op(0, 32'hFFFF_FFFE, 1'b0, 1'b0, "R7 wr even");
        rd_op(0, 32'h0, 1'b0, "R7 rd even");
        wr_op(0, 32'h0000_0003, 1'b0, 1'b0, "R7 wr odd");
        rd_op(0, 32'h1, 1'b0, "R7 rd odd");
        // R8 reset request pulse
        wr_op('h80, 32'h0000_0005, 1'b0, 1'b1, "R8 pulse");
        idle();
        idle();
        rd_op('h80, 32'h0000_0005, 1'b0, "R8 readback");
        wr_op('h80, 32'h0000_0004, 1'b0, 1'b0, "R8 bit0 clear");
        // R4 status read-only
        wr_op(3, 32'h1, 1'b1, 1'b0, "R4 wr status");
        rd_op(3, 32'h0, 1'b0, "R4 status kept");
        // R9 invalid reads
        rd_op(1, 32'h0, 1'b1, "R9 rd lock word");
        rd_op(2, 32'h0, 1'b1, "R9 rd unlock word");
        rd_op('h3FF, 32'h0, 1'b1, "R9 rd undefined");
        rd_op(BASE + NCFG, 32'h0, 1'b1, "R9 rd past range");
        rd_op(3, 32'h0, 1'b0, "R9 no state change");
        // R10 invalid writes
        wr_op('h3FF, 32'hDEAD_BEEF, 1'b1, 1'b0, "R10 wr undefined");
        wr_op(BASE + NCFG, 32'hDEAD_BEEF, 1'b1, 1'b0, "R10 wr past range");
        wr_op('h14C, 32'hDEAD_BEEF, 1'b1, 1'b0, "R10 wr id");
        // R11 identification
        rd_op('h14C, IDV, 1'b0, "R11 id");
        // R12 both strobes: write wins
        op(1'b1, 1'b1, BASE + 1, 32'h0000_0077, 32'h0, 1'b0, 1'b0, "R12 both strobes");
        rd_op(BASE + 1, 32'h0000_0077, 1'b0, "R12 write took effect");
        // R2 lock key
        wr_op(1, 32'h0000_767C, 1'b0, 1'b0, "R2 bad key");
        rd_op(3, 32'h0, 1'b0, "R2 still unlocked");
        wr_op(1, 32'hABCD_767B, 1'b0, 1'b0, "R2 lock");
        rd_op(3, 32'h1, 1'b0, "R2 locked");
        wr_op(BASE, 32'h0, 1'b1, 1'b0, "R5 relocked wr");
        rd_op(BASE, 32'hAAAA_5555, 1'b0, "R5 value kept");
        wr_op(0, 32'h0, 1'b1, 1'b0, "R5 scratch locked");
        rd_op(0, 32'h1, 1'b0, "R5 scratch kept");
        wr_op(2, 32'h0000_DF0D, 1'b0, 1'b0, "R3 unlock again");
        rd_op(3, 32'h0, 1'b0, "R3 reopened");
        idle();
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            tests++;
            fails++;
            $display("FAIL R12: %0d responses missing expected 0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule